// File: doc/BRIEF.md
# Strobed-Address One-of-Sixteen Decoder

The block keeps a 4-bit select code in a holding register and turns it into a one-of-sixteen line pattern. A strobe input controls when the code is taken. While the strobe is high, the register loads the address on each rising clock edge. While the strobe is low, the register keeps its code and ignores the address pins. The register is clocked, so it behaves as a strobed latch without inferring a level-sensitive latch.

An active-low enable acts on the output lines directly and does not pass through the register. When the enable is high, no line is selected. When the enable is low, the line indexed by the held code is selected. Driving the enable with a serial data stream routes that stream to the addressed line, so the block works as a one-to-sixteen demultiplexer. The same pin also serves as a chip select when several blocks are cascaded.

A parameter chosen at elaboration sets the output polarity. In the default active-high form, the selected line is 1 and the others are 0. In the active-low form, the selected line is 0 and the others are 1.

Top module: `lsd_latched_decoder`

## Requirements
- R1: While reset is asserted and after it is released, the held code is 0, so with the enable low only line 0 is selected until the first strobed load.
- R2: At a rising clock edge with the strobe high, the held code takes the address value (addr[3] is the most significant bit), and the lines show the new selection from that edge.
- R3: At edges with the strobe low, address changes are ignored and the held code and line pattern stay as they were.
- R4: With the enable low, exactly one line is selected, the one whose index equals the held code.
- R5: With the enable high, no line is selected, whatever the address, strobe or held code.
- R6: With POLARITY = POL_HIGH (the default), a selected line is 1 and unselected lines are 0, so a disabled block outputs all zeros.
- R7: With POLARITY = POL_LOW, a selected line is 0 and unselected lines are 1, so a disabled block outputs all ones.
- R8: The enable reaches the lines with no clock edge in between, whatever the strobe level. Toggling it mid-cycle makes the addressed line follow it (inverted for POL_HIGH, as-is for POL_LOW) and leaves every other line at its unselected level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 4 | Select code |
| strobe | input | 1 | Load strobe; high lets the held code take addr at each edge |
| en_n | input | 1 | Active-low output enable and demultiplexer data input |
| lines | output | 16 | Decoded one-of-sixteen lines |

## Verification
Address and strobe take effect one register stage later: a code presented before a rising edge with the strobe high shows on the lines right after that edge. The bench drives on the falling edge and checks half a half-period after the following rising edge. The enable has no register on its path. Its checks toggle it in the middle of a cycle and sample two nanoseconds later, with no clock edge in the window. After reset release the bench waits several cycles to cover the two-stage reset synchronizer before its first check.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } pol_e;
endpackage

// File: rtl/lsd_rst_sync.sv
module lsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lsd_addr_hold.sv
module lsd_addr_hold #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] sel_in,
  output logic [SEL_W-1:0] sel_q
);
  logic [SEL_W-1:0] sel_d;

  always_comb begin
    sel_d = sel_q;
    if (load) sel_d = sel_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/lsd_line_decode.sv
module lsd_line_decode
  import lsd_pkg::*;
#(
  parameter int   SEL_W    = 4,
  parameter pol_e POLARITY = POL_HIGH,
  localparam int  LINES    = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             en_n,
  output logic [LINES-1:0] lines
);
  logic [LINES-1:0] hit;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign hit[g] = (sel == SEL_W'(g)) & ~en_n;
    if (POLARITY == POL_LOW) begin : g_low
      assign lines[g] = ~hit[g];
    end else begin : g_high
      assign lines[g] = hit[g];
    end
  end
endmodule

// File: rtl/lsd_latched_decoder.sv
module lsd_latched_decoder
  import lsd_pkg::*;
#(
  parameter int   SEL_W    = 4,
  parameter pol_e POLARITY = POL_HIGH,
  localparam int  LINES    = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] addr,
  input  logic             strobe,
  input  logic             en_n,
  output logic [LINES-1:0] lines
);
  logic             rst_n_sync;
  logic [SEL_W-1:0] held_sel;

  lsd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lsd_addr_hold #(.SEL_W(SEL_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .load   (strobe),
    .sel_in (addr),
    .sel_q  (held_sel)
  );

  lsd_line_decode #(.SEL_W(SEL_W), .POLARITY(POLARITY)) u_dec (
    .sel   (held_sel),
    .en_n  (en_n),
    .lines (lines)
  );
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker
  import lsd_pkg::*;
#(
  parameter int   SEL_W    = 4,
  parameter pol_e POLARITY = POL_HIGH,
  localparam int  LINES    = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic [SEL_W-1:0] addr,
  input logic             strobe,
  input logic             en_n,
  input logic [SEL_W-1:0] held_sel,
  input logic [LINES-1:0] lines
);
  logic [LINES-1:0] sel_view;
  assign sel_view = (POLARITY == POL_LOW) ? ~lines : lines;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    strobe |=> held_sel == $past(addr));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !strobe |=> $stable(held_sel));

  assert_one_hot_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !en_n |-> ($countones(sel_view) == 1 && sel_view[held_sel]));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    en_n |-> sel_view == '0);
endmodule

bind lsd_latched_decoder lsd_checker #(.SEL_W(SEL_W), .POLARITY(POLARITY)) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .addr       (addr),
  .strobe     (strobe),
  .en_n       (en_n),
  .held_sel   (held_sel),
  .lines      (lines)
);

// File: tb/lsd_latched_decoder_tb.sv
module lsd_latched_decoder_tb;
  import lsd_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [3:0]  addr;
  logic        strobe;
  logic        en_n;
  logic [15:0] lines_hi;
  logic [15:0] lines_lo;

  int checks;
  int fails;
  logic [3:0] model_sel;
  bit done;

  lsd_latched_decoder #(.SEL_W(4), .POLARITY(POL_HIGH)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strobe(strobe), .en_n(en_n), .lines(lines_hi)
  );

  lsd_latched_decoder #(.SEL_W(4), .POLARITY(POL_LOW)) u_dut_inv (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strobe(strobe), .en_n(en_n), .lines(lines_lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] exp_high(input logic [3:0] s, input logic dis);
    return dis ? 16'h0000 : (16'h0001 << s);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_both(input string req);
    check({req, " high"}, lines_hi, exp_high(model_sel, en_n));
    check({req, " low"},  lines_lo, ~exp_high(model_sel, en_n));
    checks++;
    if (!en_n && $countones(lines_hi) != 1) begin
      fails++;
      $display("FAIL R4: actual=%0d expected=1 lines set", $countones(lines_hi));
    end
  endtask

  task automatic step(input logic [3:0] a, input logic s, input logic e);
    @(negedge clk);
    addr = a; strobe = s; en_n = e;
    if (s) model_sel = a;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0414));
    checks = 0; fails = 0; model_sel = 4'd0;
    rst_n = 1'b0; addr = 4'hA; strobe = 1'b1; en_n = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset high", lines_hi, 16'h0001);
    check("R1 reset low",  lines_lo, 16'hFFFE);
    @(negedge clk);
    strobe = 1'b0; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    check_both("R1 after release");

    // R2 R6 R7: every code, strobed, enabled
    for (int i = 0; i < 16; i++) begin
      step(4'(i), 1'b1, 1'b0);
      check_both("R2 R6 R7 sweep");
    end

    // R5: disabled across codes and strobe states
    for (int i = 0; i < 4; i++) begin
      step(4'(i * 5), 1'(i & 1), 1'b1);
      check_both("R5 disabled");
    end

    // R3: load 9, then change address with strobe low
    step(4'd9, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(4'(i + 2), 1'b0, 1'b0);
      check_both("R3 hold");
    end

    // R8: enable toggled mid-cycle, strobe low then high
    for (int k = 0; k < 2; k++) begin
      step(4'd12, 1'b1, 1'b0);
      @(negedge clk);
      strobe = 1'(k);
      addr = 4'd12;
      #2; en_n = 1'b1; #2;
      check_both("R8 data high");
      en_n = 1'b0; #2;
      check_both("R8 data low");
      en_n = 1'b1; #2;
      check_both("R8 data high again");
    end

    // random mix
    for (int i = 0; i < 300; i++) begin
      step(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0));
      check_both("R2 R3 R4 R5 random");
    end

    // R1 again: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0; en_n = 1'b0; strobe = 1'b0;
    model_sel = 4'd0;
    #3;
    check_both("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    check_both("R1 post reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule